// File: doc/BRIEF.md
# Tiered Error Reporting Unit

This block collects the error events an endpoint detects on its link and in its transaction handling, and sorts each one into one of three severity tiers: correctable, non-fatal uncorrectable and fatal uncorrectable. For every event it keeps a per-type counter that stops at its maximum value. It also sets a sticky status bit for the event's tier. For each tier it keeps at most one pending upstream notification.

Notifications leave through a valid/ready port that carries a 2-bit severity code. The most severe pending notification always goes out first, and a tier creates notifications only while its reporting enable is set. A fatal event also raises a one-cycle request to reset the link below. Software clears the status bits through a write-one-to-clear input, and reads each counter through a select input.

Top module: `err_tier_report`

## Requirements
- R1: Event strobe bits map to tiers as follows. Bits 0..4 are correctable: receiver error, bad TLP, bad DLLP, replay number rollover and replay timeout. Bits 5..7 are non-fatal: completion timeout, unexpected completion and access control violation. Bits 8..10 are fatal: flow control protocol error, malformed TLP and ECRC failure.
- R2: A strobe of any event in tier t sets `err_status[t]` on the next clock edge, whatever the reporting enables are (bit 0 correctable, bit 1 non-fatal, bit 2 fatal).
- R3: Status bits stay set until `status_clr[t]` is pulsed. If an event of the same tier arrives in the same cycle as the clear, the bit stays set.
- R4: Each of the 11 event types has its own counter, which adds one for each cycle its strobe is high. `cnt_val` returns the counter picked by `cnt_sel` one cycle later, as it stood before that edge. A select of 11 or more returns zero.
- R5: A counter that has reached all ones stays at all ones.
- R6: An event creates a notification only if `rpt_en[t]` for its tier is high in the same cycle. Events in a disabled tier never make `msg_valid` rise.
- R7: `msg_sev` is 2'b00 for correctable, 2'b01 for non-fatal and 2'b11 for fatal. A notification made by an event in an idle block shows `msg_valid` two edges after the event strobe.
- R8: Whenever the output is free to load, it takes the most severe pending tier: fatal first, then non-fatal, then correctable.
- R9: Each tier holds at most one pending notification. Repeated events in a tier that already has one pending do not add more notifications.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid` and `msg_sev` hold their values.
- R11: `link_rst_req` goes high for one cycle on the edge after any fatal event strobe, whatever the enables are.
- R12: After synchronous reset, the status, all counters, `cnt_val`, `msg_valid` and `link_rst_req` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_strobe | input | 11 | One-cycle error event strobes, one bit per type |
| rpt_en | input | 3 | Per-tier reporting enables (0 corr, 1 non-fatal, 2 fatal) |
| status_clr | input | 3 | Write-one-to-clear pulses for the status bits |
| err_status | output | 3 | Sticky per-tier error detected bits |
| cnt_sel | input | 4 | Counter select for readback |
| cnt_val | output | CNT_W | Registered counter readback |
| msg_valid | output | 1 | Notification available |
| msg_ready | input | 1 | Upstream accepts the notification |
| msg_sev | output | 2 | Severity code of the notification |
| link_rst_req | output | 1 | One-cycle link reset request |

## Verification
Two things can fall in the same cycle. First, an acceptance of the current notification (valid and ready both high) can coincide with new events in several tiers, including the tier just accepted. Second, a status clear can coincide with a new event of the same tier. The random phase brings both about by driving sparse event vectors, enables, clears and a ready line that drops often. Each cycle a bench model recomputes the pending set, the next notification, the status and the counters from the requirements, and compares them with the ports. Directed cases add the event and clear in one cycle, three tiers at once with ready held low, and a long burst on a single type that drives its counter into saturation.

// File: rtl/err_tier_pkg.sv
package err_tier_pkg;
  localparam int NUM_EV = 11;
  localparam int NUM_TIER = 3;

  localparam logic [NUM_EV-1:0] MASK_COR = 11'b000_0001_1111;
  localparam logic [NUM_EV-1:0] MASK_NF  = 11'b000_1110_0000;
  localparam logic [NUM_EV-1:0] MASK_FAT = 11'b111_0000_0000;

  localparam logic [1:0] SEV_COR = 2'b00;
  localparam logic [1:0] SEV_NF  = 2'b01;
  localparam logic [1:0] SEV_FAT = 2'b11;
endpackage

// File: rtl/err_sat_ctr.sv
module err_sat_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (inc && cnt != TOP)
      cnt <= cnt + 1'b1;
  end

  // R5: a full counter stays full
  a_r5_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP) |=> (cnt == TOP));

  // R4: a counter only moves by one step
  a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
    (!inc) |=> $stable(cnt));
endmodule

// File: rtl/err_msg_arb.sv
module err_msg_arb
  import err_tier_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TIER-1:0] req,
  input  logic                msg_ready,
  output logic                msg_valid,
  output logic [1:0]          msg_sev
);
  logic [NUM_TIER-1:0] pend;
  logic [NUM_TIER-1:0] pick;
  logic                load;

  always_comb begin
    load = !msg_valid || msg_ready;
    if (pend[2])      pick = 3'b100;
    else if (pend[1]) pick = 3'b010;
    else if (pend[0]) pick = 3'b001;
    else              pick = 3'b000;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      msg_valid <= 1'b0;
      msg_sev   <= SEV_COR;
    end else begin
      pend <= (pend & ~(load ? pick : 3'b000)) | req;
      if (load) begin
        msg_valid <= |pend;
        msg_sev   <= pend[2] ? SEV_FAT : (pend[1] ? SEV_NF : SEV_COR);
      end
    end
  end

  // R10: an offered notification is held until taken
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_sev)));

  // R7: only the three defined codes appear
  a_r7_code: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_sev != 2'b10));
endmodule

// File: rtl/err_tier_report.sv
module err_tier_report
  import err_tier_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_EV-1:0]   ev_strobe,
  input  logic [NUM_TIER-1:0] rpt_en,
  input  logic [NUM_TIER-1:0] status_clr,
  output logic [NUM_TIER-1:0] err_status,
  input  logic [SEL_W-1:0]    cnt_sel,
  output logic [CNT_W-1:0]    cnt_val,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [1:0]          msg_sev,
  output logic                link_rst_req
);
  logic [NUM_TIER-1:0] hit;
  logic [CNT_W-1:0]    cnt_arr [NUM_EV];

  always_comb begin
    hit[0] = |(ev_strobe & MASK_COR);
    hit[1] = |(ev_strobe & MASK_NF);
    hit[2] = |(ev_strobe & MASK_FAT);
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EV; gi++) begin : g_ctr
      err_sat_ctr #(.W(CNT_W)) u_ctr (
        .clk (clk),
        .rst (rst),
        .inc (ev_strobe[gi]),
        .cnt (cnt_arr[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      err_status   <= '0;
      cnt_val      <= '0;
      link_rst_req <= 1'b0;
    end else begin
      err_status   <= (err_status & ~status_clr) | hit;
      link_rst_req <= hit[2];
      if (int'(cnt_sel) < NUM_EV)
        cnt_val <= cnt_arr[cnt_sel];
      else
        cnt_val <= '0;
    end
  end

  err_msg_arb u_arb (
    .clk       (clk),
    .rst       (rst),
    .req       (hit & rpt_en),
    .msg_ready (msg_ready),
    .msg_valid (msg_valid),
    .msg_sev   (msg_sev)
  );

  // R2 and R3: an event always leaves its tier bit set
  a_r2_status_set: assert property (@(posedge clk) disable iff (rst)
    (|(ev_strobe & MASK_NF)) |=> err_status[1]);

  // R11: the link reset request follows a fatal event
  a_r11_rst_req: assert property (@(posedge clk) disable iff (rst)
    (|(ev_strobe & MASK_FAT)) |=> link_rst_req);

  // R11: the request never appears without a fatal cause
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!(|(ev_strobe & MASK_FAT))) |=> !link_rst_req);
endmodule

// File: tb/err_tier_report_test.sv
module err_tier_report_test;
  localparam int NE = 11;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst;
  logic [NE-1:0] ev_strobe;
  logic [2:0]    rpt_en, status_clr;
  logic [2:0]    err_status;
  logic [3:0]    cnt_sel;
  logic [CW-1:0] cnt_val;
  logic          msg_valid, msg_ready;
  logic [1:0]    msg_sev;
  logic          link_rst_req;

  int n_checks = 0;
  int n_fail = 0;

  // reference state
  int       m_cnt [NE];
  bit [2:0] m_stat, m_pend;
  bit       m_valid, m_rst;
  bit [1:0] m_sev;
  int       m_cval;

  always #2 clk = ~clk;

  err_tier_report #(.CNT_W(CW), .SEL_W(4)) uut (
    .clk(clk), .rst(rst), .ev_strobe(ev_strobe), .rpt_en(rpt_en),
    .status_clr(status_clr), .err_status(err_status), .cnt_sel(cnt_sel),
    .cnt_val(cnt_val), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_sev(msg_sev), .link_rst_req(link_rst_req)
  );

  function automatic bit [2:0] tiers(input logic [NE-1:0] ev);
    return {|ev[10:8], |ev[7:5], |ev[4:0]};
  endfunction

  function automatic bit [1:0] code_of(input int t);
    return (t == 2) ? 2'b11 : ((t == 1) ? 2'b01 : 2'b00);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NE; i++) m_cnt[i] = 0;
    m_stat = 0; m_pend = 0; m_valid = 0; m_rst = 0; m_sev = 0; m_cval = 0;
  endtask

  task automatic model_step(input logic [NE-1:0] ev, input logic [2:0] en,
                            input logic [2:0] clr, input logic rdy,
                            input logic [3:0] sel);
    bit [2:0] h;
    bit [2:0] pn;
    h = tiers(ev);
    m_cval = (sel < NE) ? m_cnt[sel] : 0;
    for (int i = 0; i < NE; i++)
      if (ev[i] && m_cnt[i] < CMAX) m_cnt[i]++;
    m_stat = (m_stat & ~clr) | h;
    m_rst = h[2];
    pn = m_pend;
    if (!m_valid || rdy) begin
      m_valid = 1'b0;
      for (int t = 2; t >= 0; t--) begin
        if (m_pend[t] && !m_valid) begin
          m_valid = 1'b1;
          m_sev = code_of(t);
          pn[t] = 1'b0;
        end
      end
    end
    m_pend = pn | (h & en);
  endtask

  task automatic step(input logic [NE-1:0] ev, input logic [2:0] en,
                      input logic [2:0] clr, input logic rdy,
                      input logic [3:0] sel);
    @(negedge clk);
    ev_strobe = ev; rpt_en = en; status_clr = clr; msg_ready = rdy; cnt_sel = sel;
    @(posedge clk);
    #1;
    model_step(ev, en, clr, rdy, sel);
    check("R2/R3 status", int'(err_status), int'(m_stat));
    check("R6/R8/R9 msg_valid", int'(msg_valid), int'(m_valid));
    if (m_valid) check("R7/R8/R10 msg_sev", int'(msg_sev), int'(m_sev));
    check("R11 link_rst_req", int'(link_rst_req), int'(m_rst));
    check("R4/R5 cnt_val", int'(cnt_val), m_cval);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; ev_strobe = '0; rpt_en = '0; status_clr = '0;
    msg_ready = 1'b0; cnt_sel = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check("R12 status", int'(err_status), 0);
    check("R12 msg_valid", int'(msg_valid), 0);
    check("R12 link_rst_req", int'(link_rst_req), 0);
    check("R12 cnt_val", int'(cnt_val), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1/R7: single fatal event, check code and two-edge latency
    step(11'b100_0000_0000, 3'b111, 3'b000, 1'b0, 4'd8);
    check("R7 latency one edge", int'(msg_valid), 0);
    step('0, 3'b111, 3'b000, 1'b0, 4'd8);
    check("R7 fatal code", int'(msg_sev), 3);
    step('0, 3'b111, 3'b000, 1'b1, 4'd8);

    // R8/R10: three tiers at once, ready low for a while
    step(11'b001_0010_0001, 3'b111, 3'b000, 1'b0, 4'd0);
    for (int k = 0; k < 4; k++) step('0, 3'b111, 3'b000, 1'b0, 4'd5);
    check("R8 fatal first", int'(msg_sev), 3);
    for (int k = 0; k < 4; k++) step('0, 3'b111, 3'b000, 1'b1, 4'd12);

    // R6: disabled tier produces nothing; R9 repeats collapse
    for (int k = 0; k < 5; k++) step(11'b000_0000_0010, 3'b110, 3'b000, 1'b1, 4'd1);
    check("R6 disabled no msg", int'(msg_valid), 0);
    for (int k = 0; k < 5; k++) step(11'b000_0100_0000, 3'b111, 3'b000, 1'b0, 4'd6);
    step('0, 3'b111, 3'b000, 1'b1, 4'd6);
    step('0, 3'b111, 3'b000, 1'b1, 4'd6);
    check("R9 single msg per tier", int'(msg_valid), 0);

    // R3: clear with and without a same-cycle event
    step(11'b000_0000_0100, 3'b000, 3'b001, 1'b1, 4'd2);
    check("R3 set wins", int'(err_status[0]), 1);
    step('0, 3'b000, 3'b111, 1'b1, 4'd2);
    check("R3 cleared", int'(err_status), 0);

    // R5: saturate counter 3
    for (int k = 0; k < CMAX + 8; k++) step(11'b000_0000_1000, 3'b000, 3'b000, 1'b1, 4'd3);
    step('0, 3'b000, 3'b000, 1'b1, 4'd3);
    check("R5 saturated", int'(cnt_val), CMAX);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic [NE-1:0] ev;
      ev = NE'($urandom & $urandom & $urandom);
      step(ev, 3'($urandom), 3'($urandom & $urandom), 1'($urandom % 3 != 0),
           4'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule